// File: doc/BRIEF.md
# Multi-mode dual-output PWM generator

This block drives a high-side and a low-side PWM output from one free-running up-counter. Four registers set its behaviour: the period, a primary duty value, a secondary duty value and an output mode. Software writes them through a single write strobe with a two-bit select. Every write lands in a shadow copy. The shadow copies move to the active copies only when the counter wraps, so a period in progress is never disturbed by a write.

The mode decides where the low output gets its pulse. In independent mode the low output has its own duty value. In the other three modes it is derived from the primary pulse: inverted, copied, or alternated with the high output on every other period. Before either duty value is compared with the counter, it is clamped to a window. The lower bound is a minimum pulse width. The upper bound is the period minus that same width. This stops the generator from producing a pulse that is too short to be useful or a gap that is too short to be useful.

Top module: `pwm_dual_gen`

## Requirements
- R1: While `rst_n` is low, both outputs are 0. When reset is released, all four registers read back as 0.
- R2: A write with `wr_en`=1 stores `wr_data` in the shadow register picked by `wr_sel`. The codes are 0 = period, 1 = primary duty, 2 = secondary duty, 3 = mode (bits [1:0]). `rd_data` returns the shadow register picked by `rd_sel` in the same cycle, and mode reads back zero-extended.
- R3: The counter counts 0, 1, …, period and then returns to 0, so one period lasts period+1 cycles. An output is high while the counter is below its effective duty value. The outputs are registered and lag the counter by one cycle.
- R4: A write to the period, a duty or the mode has no effect on the outputs until the counter next wraps. From that period on, the written value applies.
- R5: A duty value below MIN_PULSE (default 8) acts as MIN_PULSE.
- R6: A duty value above period−MIN_PULSE acts as period−MIN_PULSE. When period < 2·MIN_PULSE, the effective duty is MIN_PULSE.
- R7: In independent mode (code 0), the high output follows the primary duty and the low output follows the secondary duty.
- R8: In complementary mode (code 1), the low output is the inverse of the high output in every cycle, and the secondary duty has no effect.
- R9: In redundant mode (code 2), the low output equals the high output in every cycle.
- R10: In push-pull mode (code 3), the primary pulse goes to the high output on even periods and to the low output on odd periods. The other output stays low, so the two outputs are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | W | Write data |
| rd_sel | input | 2 | Register select for read-back |
| rd_data | output | W | Shadow register contents |
| pwm_hi | output | 1 | High-side PWM output |
| pwm_lo | output | 1 | Low-side PWM output |

## Verification
The bench uses the defaults, W=16 and MIN_PULSE=8. This keeps the clamp window at eight counts, so periods of 10 to 200 cycles reach both clamp bounds, the case where the period is too short for the window, and several wraps per test within a short run. Measuring over two full periods makes the high and low counts independent of phase. It also covers both push-pull phases. A mid-period write to a 200-cycle period shows that the new duty value is held back until the next wrap.

// File: rtl/pwm_dual_pkg.sv
// Shared codes for the dual-output PWM generator.
// Assumes: register select and mode are two-bit fields.
package pwm_dual_pkg;
    typedef enum logic [1:0] {
        MODE_INDEP    = 2'd0,
        MODE_COMP     = 2'd1,
        MODE_REDUN    = 2'd2,
        MODE_PUSHPULL = 2'd3
    } pwm_mode_e;

    localparam logic [1:0] SEL_PERIOD = 2'd0;
    localparam logic [1:0] SEL_DUTY_A = 2'd1;
    localparam logic [1:0] SEL_DUTY_B = 2'd2;
    localparam logic [1:0] SEL_MODE   = 2'd3;
endpackage

// File: rtl/pwm_dual_regs.sv
// Shadow and active register bank.
// Writes land in the shadow copies. The active copies reload only on wrap.
// Assumes: W > 2.
module pwm_dual_regs
    import pwm_dual_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    input  logic         wrap,
    output logic [W-1:0] per_act,
    output logic [W-1:0] duty_a_act,
    output logic [W-1:0] duty_b_act,
    output logic [1:0]   mode_act
);
    logic [W-1:0] per_sh, duty_a_sh, duty_b_sh;
    logic [1:0]   mode_sh;

    // Shadow capture from the write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh    <= '0;
            duty_a_sh <= '0;
            duty_b_sh <= '0;
            mode_sh   <= MODE_INDEP;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_PERIOD: per_sh    <= wr_data;
                SEL_DUTY_A: duty_a_sh <= wr_data;
                SEL_DUTY_B: duty_b_sh <= wr_data;
                default:    mode_sh   <= wr_data[1:0];
            endcase
        end
    end

    // Active copy reload at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act    <= '0;
            duty_a_act <= '0;
            duty_b_act <= '0;
            mode_act   <= MODE_INDEP;
        end else if (wrap) begin
            per_act    <= per_sh;
            duty_a_act <= duty_a_sh;
            duty_b_act <= duty_b_sh;
            mode_act   <= mode_sh;
        end
    end

    // Read-back multiplexer over shadow copies
    always_comb begin
        case (rd_sel)
            SEL_PERIOD: rd_data = per_sh;
            SEL_DUTY_A: rd_data = duty_a_sh;
            SEL_DUTY_B: rd_data = duty_b_sh;
            default:    rd_data = {{(W-2){1'b0}}, mode_sh};
        endcase
    end
endmodule

// File: rtl/pwm_dual_timebase.sv
// Free-running period counter: counts 0..per and flags the wrap cycle.
// Assumes: per may change only on the wrap cycle.
module pwm_dual_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // Wrap when the count reaches the active period
    always_comb wrap = (cnt >= per);

    // Count step, back to zero on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (wrap) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_dual_clamp.sv
// Duty clamp into [MIN_PULSE, per-MIN_PULSE].
// If per < 2*MIN_PULSE, the result is MIN_PULSE.
// Assumes: MIN_PULSE fits in W bits.
module pwm_dual_clamp #(
    parameter int W         = 16,
    parameter int MIN_PULSE = 8
) (
    input  logic [W-1:0] duty,
    input  logic [W-1:0] per,
    output logic [W-1:0] eff
);
    localparam logic [W:0]   TWO_MIN = (W+1)'(2 * MIN_PULSE);
    localparam logic [W-1:0] LO      = W'(MIN_PULSE);
    logic [W-1:0] hi;

    // Upper bound from the period, held at the lower bound for short periods
    always_comb hi = ({1'b0, per} >= TWO_MIN) ? (per - LO) : LO;

    // Saturate the duty into the window
    always_comb begin
        if (duty < LO) eff = LO;
        else if (duty > hi) eff = hi;
        else eff = duty;
    end
endmodule

// File: rtl/pwm_dual_steer.sv
// Compare and mode steering with registered outputs.
// Keeps a period-parity bit for push-pull. The bit toggles on every wrap.
// Assumes: mode and the effective duties are stable within a period.
module pwm_dual_steer
    import pwm_dual_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         wrap,
    input  logic [W-1:0] eff_a,
    input  logic [W-1:0] eff_b,
    input  logic [1:0]   mode,
    output logic         pwm_hi,
    output logic         pwm_lo
);
    logic odd_q;
    logic raw_a, raw_b;
    logic hi_d, lo_d;

    // Raw compares against both effective duties
    always_comb begin
        raw_a = (cnt < eff_a);
        raw_b = (cnt < eff_b);
    end

    // Route the raw pulses according to the mode
    always_comb begin
        case (pwm_mode_e'(mode))
            MODE_INDEP:    begin hi_d = raw_a;           lo_d = raw_b;          end
            MODE_COMP:     begin hi_d = raw_a;           lo_d = ~raw_a;         end
            MODE_REDUN:    begin hi_d = raw_a;           lo_d = raw_a;          end
            default:       begin hi_d = raw_a & ~odd_q;  lo_d = raw_a & odd_q;  end
        endcase
    end

    // Period parity for push-pull alternation
    always_ff @(posedge clk) begin
        if (!rst_n) odd_q <= 1'b0;
        else if (wrap) odd_q <= ~odd_q;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_hi <= 1'b0;
            pwm_lo <= 1'b0;
        end else begin
            pwm_hi <= hi_d;
            pwm_lo <= lo_d;
        end
    end
endmodule

// File: rtl/pwm_dual_gen.sv
// Top level of the multi-mode dual-output PWM generator.
// It ties together the register bank, the timebase, two duty clamps and output steering.
// Assumes: a synchronous active-low reset and a single clock.
module pwm_dual_gen
    import pwm_dual_pkg::*;
#(
    parameter int W         = 16,
    parameter int MIN_PULSE = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic         pwm_hi,
    output logic         pwm_lo
);
    localparam int NDUTY = 2;

    logic [W-1:0] per_act, duty_a_act, duty_b_act;
    logic [1:0]   mode_act;
    logic [W-1:0] cnt_q;
    logic         wrap;
    logic [W-1:0] duty_vec [NDUTY];
    logic [W-1:0] eff_vec  [NDUTY];
    logic [W-1:0] eff_a, eff_b;

    pwm_dual_regs #(.W(W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .wrap(wrap),
        .per_act(per_act), .duty_a_act(duty_a_act),
        .duty_b_act(duty_b_act), .mode_act(mode_act)
    );

    pwm_dual_timebase #(.W(W)) tb_i (
        .clk(clk), .rst_n(rst_n), .per(per_act), .cnt(cnt_q), .wrap(wrap)
    );

    // Collect both duty sources for the clamp array
    always_comb begin
        duty_vec[0] = duty_a_act;
        duty_vec[1] = duty_b_act;
    end

    for (genvar g = 0; g < NDUTY; g++) begin : g_clamp
        pwm_dual_clamp #(.W(W), .MIN_PULSE(MIN_PULSE)) clamp_i (
            .duty(duty_vec[g]), .per(per_act), .eff(eff_vec[g])
        );
    end

    // Name the clamp results
    always_comb begin
        eff_a = eff_vec[0];
        eff_b = eff_vec[1];
    end

    pwm_dual_steer #(.W(W)) steer_i (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .wrap(wrap),
        .eff_a(eff_a), .eff_b(eff_b), .mode(mode_act),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );
endmodule

// File: rtl/pwm_dual_gen_chk.sv
// Assertion checker for pwm_dual_gen. It is bound to the top below.
// Assumes: it sees the active registers, the counter and the clamp outputs.
module pwm_dual_gen_chk #(
    parameter int W         = 16,
    parameter int MIN_PULSE = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] per_act,
    input logic [W-1:0] duty_a_act,
    input logic [1:0]   mode_act,
    input logic [W-1:0] eff_a,
    input logic [W-1:0] eff_b,
    input logic         pwm_hi,
    input logic         pwm_lo
);
    localparam logic [W-1:0] LO = W'(MIN_PULSE);
    localparam logic [W:0]   TWO_MIN = (W+1)'(2 * MIN_PULSE);

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_act); // R3
    AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> ($stable(per_act) && $stable(duty_a_act) && $stable(mode_act))); // R4
    AST_CLAMP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_a >= LO) && (eff_b >= LO)); // R5
    AST_CLAMP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, per_act} >= TWO_MIN) |-> ((eff_a <= per_act - LO) && (eff_b <= per_act - LO))); // R6
    AST_COMP_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_act) == 2'd1 && $past(rst_n)) |-> (pwm_lo != pwm_hi)); // R8
    AST_REDUN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_act) == 2'd2) |-> (pwm_lo == pwm_hi)); // R9
    AST_PP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_hi && pwm_lo && $past(mode_act) == 2'd3)); // R10
endmodule

bind pwm_dual_gen pwm_dual_gen_chk #(.W(W), .MIN_PULSE(MIN_PULSE)) chk_i (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .per_act(per_act),
    .duty_a_act(duty_a_act), .mode_act(mode_act),
    .eff_a(eff_a), .eff_b(eff_b), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
);

// File: tb/pwm_dual_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_dual_gen_tb_top;
    localparam int W = 16;
    localparam int NV = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_sel = '0;
    logic [W-1:0] rd_data;
    logic         pwm_hi, pwm_lo;

    int total = 0;
    int bad = 0;
    int prev_per = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_dual_gen #(.W(W), .MIN_PULSE(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    // {period, primary, secondary, mode, expected high count, expected low count}
    // The counts are taken over a window of two periods.
    localparam logic [81:0] VEC [NV] = '{
        {16'd99, 16'd30,   16'd60,  2'd0, 16'd60,  16'd120}, // R7
        {16'd99, 16'd3,    16'd200, 2'd0, 16'd16,  16'd182}, // R5 R6
        {16'd49, 16'd20,   16'd5,   2'd1, 16'd40,  16'd60},  // R8
        {16'd49, 16'd0,    16'd0,   2'd1, 16'd16,  16'd84},  // R8 R5
        {16'd39, 16'd25,   16'd0,   2'd2, 16'd50,  16'd50},  // R9
        {16'd39, 16'd1000, 16'd0,   2'd2, 16'd62,  16'd62},  // R9 R6
        {16'd59, 16'd20,   16'd0,   2'd3, 16'd20,  16'd20},  // R10
        {16'd59, 16'd55,   16'd0,   2'd3, 16'd51,  16'd51},  // R10 R6
        {16'd9,  16'd5,    16'd0,   2'd0, 16'd16,  16'd16}   // R6
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input int n, output int hc, output int lc,
                           output int both, output int diff);
        hc = 0; lc = 0; both = 0; diff = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hc += int'(pwm_hi);
            lc += int'(pwm_lo);
            both += int'(pwm_hi & pwm_lo);
            diff += int'(pwm_hi != pwm_lo);
        end
    endtask

    task automatic wait_rise_hi();
        logic last;
        last = pwm_hi;
        forever begin
            @(negedge clk);
            if (pwm_hi && !last) break;
            last = pwm_hi;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hc, lc, both, diff, per, win, run;
        // R1: outputs low during reset, registers zero
        idle(3);
        check("R1 hi in reset", int'(pwm_hi), 0);
        check("R1 lo in reset", int'(pwm_lo), 0);
        @(negedge clk); rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            check("R1 reg reset", int'(rd_data), 0);
        end

        // R2: read-back of each shadow register
        wr(2'd0, 16'd123); wr(2'd1, 16'd45); wr(2'd2, 16'd67); wr(2'd3, 16'hFFFE);
        rd_sel = 2'd0; #1; check("R2 period rb", int'(rd_data), 123);
        rd_sel = 2'd1; #1; check("R2 primary rb", int'(rd_data), 45);
        rd_sel = 2'd2; #1; check("R2 secondary rb", int'(rd_data), 67);
        rd_sel = 2'd3; #1; check("R2 mode rb", int'(rd_data), 2);
        prev_per = 123;

        // Vector table: R3 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            per = int'(VEC[v][81:66]);
            win = 2 * (per + 1);
            wr(2'd0, VEC[v][81:66]);
            wr(2'd1, VEC[v][65:50]);
            wr(2'd2, VEC[v][49:34]);
            wr(2'd3, {14'd0, VEC[v][33:32]});
            idle(2 * (prev_per + 1) + 2 * (per + 1) + 4);
            measure(win, hc, lc, both, diff);
            check($sformatf("R3 vec%0d hi count", v), hc, int'(VEC[v][31:16]));
            check($sformatf("R3 vec%0d lo count", v), lc, int'(VEC[v][15:0]));
            case (VEC[v][33:32])
                2'd1: check($sformatf("R8 vec%0d inverse", v), diff, win);
                2'd2: check($sformatf("R9 vec%0d copy", v), diff, 0);
                2'd3: check($sformatf("R10 vec%0d exclusive", v), both, 0);
                default: ;
            endcase
            prev_per = per;
        end

        // R8: secondary duty has no effect in complementary mode
        wr(2'd0, 16'd49); wr(2'd1, 16'd20); wr(2'd2, 16'd10); wr(2'd3, 16'd1);
        idle(2 * (prev_per + 1) + 2 * 50 + 4);
        wr(2'd2, 16'd40);
        idle(2 * 50 + 4);
        measure(100, hc, lc, both, diff);
        check("R8 secondary ignored hi", hc, 40);
        check("R8 secondary ignored lo", lc, 60);
        prev_per = 49;

        // R4: a mid-period duty write waits for the wrap
        wr(2'd0, 16'd199); wr(2'd1, 16'd50); wr(2'd3, 16'd0);
        idle(2 * (prev_per + 1) + 2 * 200 + 4);
        wait_rise_hi();
        idle(60);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd150;
        @(negedge clk);
        wr_en = 1'b0;
        measure(110, hc, lc, both, diff);
        check("R4 held until wrap", hc, 0);
        wait_rise_hi();
        run = 1;
        while (pwm_hi) begin
            @(negedge clk);
            if (pwm_hi) run++;
        end
        check("R4 new duty after wrap", run, 150);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule